// File: doc/BRIEF.md
# Dual-Input Edge Capture Timer

This timer peripheral keeps a 16-bit count that advances on every clock and records its value when either of two asynchronous input pins changes level. Each pin has a byte-wide register for rising transitions and another for falling transitions. Normally a register stores an 8-bit slice of the count, and a 3-bit prescale setting chooses the slice. Channel 0 can also record the full 16-bit count. In that mode channel 1 stops recording its own pin, and its two registers hold the upper byte of channel 0's timestamps.

Software reaches the block through a byte-wide register port. A read has no wait state. It returns data combinationally from the address presented in the same cycle. A write or read strobe takes effect at the next clock edge. A sticky status bit records each capture. Writing a one to a status bit clears it. Each channel has its own interrupt line, and only enabled status bits drive it. In first-edge-hold mode a register keeps its first timestamp until software reads it. This lets software measure a single pulse while later edges arrive.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset the count is 0, and it rises by one on each clock. The pin is synchronised through two flops. If a level change is first seen at clock edge n, the register loads at edge n+2 and stores the count held during the cycle that ends at edge n+2.
- R2: The four capture registers are at these byte addresses: channel 0 rise 0x22, channel 1 rise 0x23, channel 0 fall 0x24, channel 1 fall 0x25. A rising transition loads only its channel's rise register. A falling transition loads only its channel's fall register.
- R3: In 8-bit mode with prescale P (0..7), a capture stores count bits [P+7:P].
- R4: When hold is clear, every edge overwrites its register. When hold is set, a register that has loaded keeps its value and ignores later edges until it is read. An ignored edge does not set a status bit.
- R5: When wide mode is set, a channel 0 edge loads count[7:0] into the channel 0 register for that edge, and count[15:8] into the matching channel 1 register.
- R6: In wide mode, edges on the channel 1 pin change no register and set no status bit.
- R7: In wide mode with hold, a read of a channel 0 register re-arms both that register and its channel 1 partner. A read of only the channel 1 partner re-arms neither.
- R8: Status is at 0x2C with this bit layout: bit0 channel 0 rise, bit1 channel 0 fall, bit2 channel 1 rise, bit3 channel 1 fall. A bit sets when its register loads. Writing 1 clears a bit. Writing 0 leaves it unchanged.
- R9: Configuration is at 0x2A. Bit 7 is hold, bits 6:4 are the prescale, and bit 3 is wide mode.
- R10: Reserved bits read as 0: configuration bits 2:0, and bits 7:4 of enable and status.
- R11: The interrupt enable register is at 0x2B and uses the status bit layout. irq_o[c] is high while any status bit of channel c has its enable bit set.
- R12: After reset every register reads 0x00 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_i | input | 2 | Asynchronous capture pins, bit c is channel c |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe (re-arms held registers) |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 2 | Per-channel interrupt |

## Verification
A pin change that the bench drives just after clock edge n-1 shows in the capture register and the status bit after edge n+2. The bench therefore computes the expected stamp as its own edge count at drive time plus two. It waits several clocks before it reads anything. Status and enable writes take effect at the next edge, and the interrupt lines follow in the same cycle. The bench drives at falling edges and samples read data one nanosecond later, so every check falls between active edges. The prescale sweep covers all eight windows on both channels. The hold and wide-mode runs use timestamps above 255, so the high byte is not zero.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int PRE_W  = 3;
  localparam int N_CH   = 2;
  localparam int N_CAP  = 2 * N_CH;

  localparam logic [7:0] ADR_RISE0 = 8'h22;
  localparam logic [7:0] ADR_CFG   = 8'h2A;
  localparam logic [7:0] ADR_IEN   = 8'h2B;
  localparam logic [7:0] ADR_STS   = 8'h2C;

  typedef struct packed {
    logic             hold;
    logic [PRE_W-1:0] pre;
    logic             wide;
  } cfg_t;
endpackage

// File: rtl/ect_edge_det.sv
module ect_edge_det #(
  parameter int SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_W-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_W-2:0], pin_i};
      prev_q <= sync_q[SYNC_W-1];
    end
  end

  assign rise_o = sync_q[SYNC_W-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_W-1] & prev_q;

  // one event per transition
  assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ect_cap_reg.sv
module ect_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         edge_i,
  input  logic         rearm_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o,
  output logic         load_o
);
  logic locked_q;

  assign load_o = edge_i & (~hold_i | ~locked_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o      <= '0;
      locked_q <= 1'b0;
    end else begin
      if (load_o) q_o <= din_i;
      if (!hold_i)      locked_q <= 1'b0;
      else if (load_o)  locked_q <= 1'b1;
      else if (rearm_i) locked_q <= 1'b0;
    end
  end

  assert_hold_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && locked_q) |=> $stable(q_o));
  assert_load_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (q_o == $past(din_i)));
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int SYNC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   cap_i,
  input  logic [7:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_en_i,
  output logic [7:0]        rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [CNT_W-1:0]  cnt_q;
  cfg_t              cfg_q;
  logic [N_CAP-1:0]  ien_q, sts_q, ev, ld, sts_set;
  logic [BYTE_W-1:0] win;
  logic [BYTE_W-1:0] capq [N_CAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign win = cnt_q[cfg_q.pre +: BYTE_W];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ect_edge_det #(.SYNC_W(SYNC_W)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_i[c]),
      .rise_o (ev[2*c]),
      .fall_o (ev[2*c+1])
    );
    for (genvar f = 0; f < 2; f++) begin : g_edge
      localparam int         IDX = 2*c + f;
      localparam logic [7:0] ADR = ADR_RISE0 + 8'(c) + 8'(2*f);
      localparam logic [7:0] LO  = ADR_RISE0 + 8'(2*f);
      logic              edge_sel, rearm;
      logic [BYTE_W-1:0] din;
      if (c == 0) begin : g_lo
        assign edge_sel = ev[IDX];
        assign din      = cfg_q.wide ? cnt_q[BYTE_W-1:0] : win;
        assign rearm    = rd_en_i && addr_i == ADR;
      end else begin : g_hi
        // wide mode: follow channel 0 edges, re-arm with the low byte
        assign edge_sel = cfg_q.wide ? ev[f] : ev[IDX];
        assign din      = cfg_q.wide ? cnt_q[CNT_W-1:BYTE_W] : win;
        assign rearm    = rd_en_i && addr_i == (cfg_q.wide ? LO : ADR);
      end
      ect_cap_reg #(.W(BYTE_W)) u_cap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hold_i  (cfg_q.hold),
        .edge_i  (edge_sel),
        .rearm_i (rearm),
        .din_i   (din),
        .q_o     (capq[IDX]),
        .load_o  (ld[IDX])
      );
      if (c == 0) begin : g_s0
        assign sts_set[IDX] = ld[IDX];
      end else begin : g_s1
        assign sts_set[IDX] = ld[IDX] & ~cfg_q.wide;
      end
    end
    assign irq_o[c] = |(sts_q[2*c +: 2] & ien_q[2*c +: 2]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADR_CFG) cfg_q <= cfg_t'(wdata_i[7:3]);
      if (wr_en_i && addr_i == ADR_IEN) ien_q <= wdata_i[N_CAP-1:0];
      // a new capture wins over a simultaneous clear
      sts_q <= (sts_q & ~((wr_en_i && addr_i == ADR_STS) ? wdata_i[N_CAP-1:0] : '0))
               | sts_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_RISE0:        rdata_o = capq[0];
      ADR_RISE0 + 8'd1: rdata_o = capq[2];
      ADR_RISE0 + 8'd2: rdata_o = capq[1];
      ADR_RISE0 + 8'd3: rdata_o = capq[3];
      ADR_CFG:          rdata_o = {cfg_q, 3'b000};
      ADR_IEN:          rdata_o = {4'h0, ien_q};
      ADR_STS:          rdata_o = {4'h0, sts_q};
      default:          rdata_o = '0;
    endcase
  end

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADR_STS && wdata_i[0] && !ld[0]) |=> !sts_q[0]);
  assert_sts_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[1]) |-> $past(ld[1]));
  assert_wide_ch1_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[2]) |-> !$past(cfg_q.wide));
endmodule

// File: tb/edge_capture_timer_tb.sv
`timescale 1ns/1ps
module edge_capture_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cap = 2'b00;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] irq;
  int         cyc = 0;
  int         checks = 0, failures = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  edge_capture_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cap_i(cap), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = int'(rdata);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int ch, input int w, output int tr, output int tf);
    @(negedge clk); cap[ch] = 1'b1; tr = (cyc + 2) % 65536;
    repeat (w) @(negedge clk);
    cap[ch] = 1'b0; tf = (cyc + 2) % 65536;
    repeat (5) @(negedge clk);
  endtask

  function automatic int slice(input int t, input int p);
    return (t >> p) & 255;
  endfunction

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d, tr, tf, r1, f1, r2, f2, r3, f3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    for (int a = 8'h22; a <= 8'h25; a++) begin rd(8'(a), d); chk("R12 cap reset", d, 0); end
    rd(8'h2A, d); chk("R12 cfg reset", d, 0);
    rd(8'h2B, d); chk("R12 ien reset", d, 0);
    rd(8'h2C, d); chk("R12 sts reset", d, 0);
    chk("R12 irq reset", int'(irq), 0);

    // R3 R2 R1 prescale sweep, both channels
    for (int p = 0; p < 8; p++) begin
      wr(8'h2A, 8'(p << 4));
      wr(8'h2C, 8'h0F);
      for (int ch = 0; ch < 2; ch++) begin
        pulse(ch, 3 + p + ch, tr, tf);
        rd(8'(8'h22 + ch), d); chk("R3 rise window", d, slice(tr, p));
        rd(8'(8'h24 + ch), d); chk("R3 fall window", d, slice(tf, p));
      end
      rd(8'h2C, d); chk("R8 status all set", d, 8'h0F);
    end

    // R8 write-one-to-clear
    wr(8'h2C, 8'h05); rd(8'h2C, d); chk("R8 w1c", d, 8'h0A);
    wr(8'h2C, 8'h00); rd(8'h2C, d); chk("R8 write zero keeps", d, 8'h0A);

    // R11 interrupts
    wr(8'h2B, 8'h02); #1 chk("R11 irq ch0", int'(irq), 1);
    wr(8'h2B, 8'h04); #1 chk("R11 irq masked", int'(irq), 0);
    wr(8'h2B, 8'h08); #1 chk("R11 irq ch1", int'(irq), 2);
    wr(8'h2C, 8'h0F); #1 chk("R11 irq cleared", int'(irq), 0);
    wr(8'h2B, 8'h00);

    // R4 latest edge
    wr(8'h2A, 8'h00);
    pulse(0, 4, r1, f1); pulse(0, 6, r2, f2);
    rd(8'h22, d); chk("R4 latest rise", d, slice(r2, 0));
    rd(8'h24, d); chk("R4 latest fall", d, slice(f2, 0));

    // R4 first-edge hold
    wr(8'h2A, 8'h80);
    pulse(0, 4, r1, f1);
    wr(8'h2C, 8'h0F);
    pulse(0, 5, r2, f2);
    rd(8'h2C, d); chk("R4 ignored edge no status", d, 0);
    rd(8'h22, d); chk("R4 held rise", d, slice(r1, 0));
    rd(8'h24, d); chk("R4 held fall", d, slice(f1, 0));
    pulse(0, 3, r3, f3);
    rd(8'h22, d); chk("R4 rearmed rise", d, slice(r3, 0));
    rd(8'h24, d); chk("R4 rearmed fall", d, slice(f3, 0));

    // R5 wide mode
    wr(8'h2A, 8'h08);
    wr(8'h2C, 8'h0F);
    pulse(0, 7, tr, tf);
    rd(8'h22, d); chk("R5 rise lo", d, tr & 255);
    rd(8'h23, d); chk("R5 rise hi", d, (tr >> 8) & 255);
    rd(8'h24, d); chk("R5 fall lo", d, tf & 255);
    rd(8'h25, d); chk("R5 fall hi", d, (tf >> 8) & 255);
    rd(8'h2C, d); chk("R5 status ch0 only", d, 8'h03);

    // R6 channel 1 pin ignored in wide mode
    wr(8'h2C, 8'h0F);
    pulse(1, 4, r1, f1);
    rd(8'h2C, d); chk("R6 no status", d, 0);
    rd(8'h23, d); chk("R6 rise hi kept", d, (tr >> 8) & 255);
    rd(8'h25, d); chk("R6 fall hi kept", d, (tf >> 8) & 255);

    // R7 wide mode with hold
    wr(8'h2A, 8'h88);
    pulse(0, 4, r1, f1);
    pulse(0, 4, r2, f2);
    rd(8'h23, d); chk("R7 hi held", d, (r1 >> 8) & 255);
    pulse(0, 4, r2, f2);
    rd(8'h23, d); chk("R7 hi read no rearm", d, (r1 >> 8) & 255);
    rd(8'h22, d); chk("R7 lo held", d, r1 & 255);
    pulse(0, 9, r3, f3);
    rd(8'h22, d); chk("R7 lo rearmed", d, r3 & 255);
    rd(8'h23, d); chk("R7 hi rearmed", d, (r3 >> 8) & 255);

    // R10 R9 reserved bits
    wr(8'h2A, 8'hFF); rd(8'h2A, d); chk("R10 cfg reserved", d, 8'hF8);
    wr(8'h2B, 8'hFF); rd(8'h2B, d); chk("R10 ien reserved", d, 8'h0F);
    wr(8'h2A, 8'h50); rd(8'h2A, d); chk("R9 cfg readback", d, 8'h50);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule